// File: doc/BRIEF.md
# SPI Slave Register Bank

This block lets an external SPI master reach a small register file. Eight 8-bit read/write configuration registers sit behind addresses 0 to 7 and drive the parallel `cfg_o` output bus. Eight 8-bit read-only status values are taken from the parallel `status_i` input bus and sit behind addresses 8 to 15. Each access is one chip-select frame of exactly 16 bits. The first byte holds a direction flag and a 4-bit address. The second byte carries the write data in or the read data out.

The SPI pins are asynchronous to the system clock `clk`. The block passes them through two-flop synchronizers and finds the SCLK edges in the system clock domain. The `cpol_i` and `cpha_i` pins choose the clock polarity and phase at run time, so all four SPI modes work. Operation is guaranteed for an SCLK up to one twentieth of `clk`. The block has no tri-state: `miso_o` is a plain output that stays low whenever the block has no read data to send.

Top module: `spi_regbank`

## Requirements
- R1: A frame holds 16 bits, MSB first. Bit 15 set to 1 marks a write, bits 11:8 give the address and bits 7:0 the data. A write to addresses 0 to 7 loads the data into configuration register `addr`, which appears on `cfg_o[addr*8 +: 8]`.
- R2: Bits 14:12 of a frame have no effect on decoding.
- R3: A read frame (bit 15 = 0) returns the addressed value on MISO during bits 7:0, MSB first. Addresses 0 to 7 return configuration register `addr`. Addresses 8 to 15 return `status_i[(addr-8)*8 +: 8]`.
- R4: A write to addresses 8 to 15 is dropped and leaves every configuration register unchanged.
- R5: MISO is 0 during bits 15:8 of every frame, during all of a write frame, and while CS_n is high.
- R6: All four SPI modes work. CPOL gives the idle SCLK level. With CPHA=0, data is sampled on the leading edge and changed on the trailing edge. With CPHA=1, data is changed on the leading edge and sampled on the trailing edge.
- R7: If CS_n rises before the 16th bit, the partial frame is abandoned and no register is written. The next frame is decoded from its bit 15.
- R8: The read value is captured once the 8 command bits are in. Later changes on `status_i` do not alter the byte being shifted out.
- R9: After reset all configuration registers are 0 and MISO is 0.
- R10: Configuration registers change only in the cycle after a committed write to addresses 0 to 7. Read frames leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20x the SCLK rate |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | SPI serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| csn_i | input | 1 | Active-low chip select |
| cpol_i | input | 1 | Clock polarity select (idle SCLK level) |
| cpha_i | input | 1 | Clock phase select |
| status_i | input | 64 | Eight read-only status bytes; byte k sits at address 8+k |
| miso_o | output | 1 | Serial data to the master |
| cfg_o | output | 64 | Eight configuration bytes; byte k is register k |

## Verification
The assertions check every cycle that the sample and shift events never coincide and that a write strobe lasts one cycle and follows a selected cycle. They also check that MISO is low after a deselected cycle and that the configuration bus holds its value unless a strobe precedes the change. Frame-level behaviour can only be shown by the bench's scenarios. This includes the bit ordering in each of the four modes, the dropped writes to the read-only half and the ignored bits 14:12. It also includes the abandoned partial frames and the status byte holding steady while `status_i` changes in the middle of a read.

// File: rtl/spireg_pkg.sv
`timescale 1ns/1ps
package spireg_pkg;

    parameter int DATA_W      = 8;
    parameter int REG_IDX_W   = 3;
    parameter int SYNC_STAGES = 2;

    localparam int NUM_REGS  = 1 << REG_IDX_W;
    localparam int ADDR_W    = REG_IDX_W + 1;
    localparam int FRAME_W   = 2 * DATA_W;
    localparam int BIT_CNT_W = $clog2(DATA_W);
    localparam int OUT_CNT_W = $clog2(FRAME_W + 1);
    localparam int BUS_W     = NUM_REGS * DATA_W;

    // Decoded command byte: direction flag and register address
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    // One-cycle events derived from synchronized SCLK
    typedef struct packed {
        logic sample;
        logic shift;
    } spi_evt_t;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_DATA,
        PH_DONE
    } phase_e;

    // Upper half of the address space is read-only status
    function automatic logic is_status_addr(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1];
    endfunction

    function automatic logic [REG_IDX_W-1:0] reg_index(input logic [ADDR_W-1:0] a);
        return a[REG_IDX_W-1:0];
    endfunction

endpackage

// File: rtl/spireg_sync.sv
`timescale 1ns/1ps
module spireg_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/spireg_edge.sv
`timescale 1ns/1ps
module spireg_edge
    import spireg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk_s,
    input  logic     cpol,
    input  logic     cpha,
    input  logic     cs_act,
    output spi_evt_t evt
);

    logic sclk_d;
    logic rise, fall, lead, trail;

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= sclk_s;
    end

    always_comb begin
        rise  = sclk_s & ~sclk_d;
        fall  = ~sclk_s & sclk_d;
        // Leading edge leaves the idle level, trailing edge returns to it
        lead  = cpol ? fall : rise;
        trail = cpol ? rise : fall;
        evt.sample = cs_act & (cpha ? trail : lead);
        evt.shift  = cs_act & (cpha ? lead : trail);
    end

endmodule

// File: rtl/spireg_frame.sv
`timescale 1ns/1ps
module spireg_frame
    import spireg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_act,
    input  logic                 mosi_s,
    input  logic                 cpha,
    input  spi_evt_t             evt,
    input  logic [DATA_W-1:0]    rd_data_i,
    output logic [ADDR_W-1:0]    peek_addr_o,
    output logic                 wr_stb_o,
    output logic [REG_IDX_W-1:0] wr_idx_o,
    output logic [DATA_W-1:0]    wr_data_o,
    output logic                 miso_o
);

    phase_e                phase;
    logic [BIT_CNT_W-1:0]  bit_cnt;
    logic [OUT_CNT_W-1:0]  out_cnt;
    logic [DATA_W-2:0]     shreg;
    logic [DATA_W-1:0]     shift_in;
    cmd_t                  cmd_peek;
    cmd_t                  cmd_q;
    logic [DATA_W-1:0]     rd_q;
    logic                  rd_ok;
    logic [OUT_CNT_W-1:0]  bit_sel;

    assign shift_in     = {shreg, mosi_s};
    assign cmd_peek.wr  = shift_in[DATA_W-1];
    assign cmd_peek.addr = shift_in[ADDR_W-1:0];
    assign peek_addr_o  = cmd_peek.addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_CMD;
            bit_cnt   <= '0;
            out_cnt   <= '0;
            shreg     <= '0;
            cmd_q     <= '0;
            rd_q      <= '0;
            rd_ok     <= 1'b0;
            wr_stb_o  <= 1'b0;
            wr_idx_o  <= '0;
            wr_data_o <= '0;
        end else if (!cs_act) begin
            // Deselect abandons any partial frame
            phase    <= PH_CMD;
            bit_cnt  <= '0;
            out_cnt  <= cpha ? OUT_CNT_W'(0) : OUT_CNT_W'(1);
            rd_ok    <= 1'b0;
            wr_stb_o <= 1'b0;
        end else begin
            wr_stb_o <= 1'b0;
            if (evt.sample) begin
                shreg <= shift_in[DATA_W-2:0];
                case (phase)
                    PH_CMD: begin
                        if (bit_cnt == BIT_CNT_W'(DATA_W-1)) begin
                            cmd_q   <= cmd_peek;
                            rd_q    <= rd_data_i;
                            rd_ok   <= ~cmd_peek.wr;
                            phase   <= PH_DATA;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        if (bit_cnt == BIT_CNT_W'(DATA_W-1)) begin
                            phase <= PH_DONE;
                            if (cmd_q.wr && !is_status_addr(cmd_q.addr)) begin
                                wr_stb_o  <= 1'b1;
                                wr_idx_o  <= reg_index(cmd_q.addr);
                                wr_data_o <= shift_in;
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            if (evt.shift && out_cnt != OUT_CNT_W'(FRAME_W))
                out_cnt <= out_cnt + 1'b1;
        end
    end

    // out_cnt counts bits presented so far; bit (out_cnt-1) is on the line
    assign bit_sel = OUT_CNT_W'(FRAME_W) - out_cnt;

    always_comb begin
        miso_o = 1'b0;
        if (rd_ok && out_cnt > OUT_CNT_W'(DATA_W))
            miso_o = rd_q[bit_sel[BIT_CNT_W-1:0]];
    end

endmodule

// File: rtl/spireg_cfgbank.sv
`timescale 1ns/1ps
module spireg_cfgbank
    import spireg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_stb,
    input  logic [REG_IDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [BUS_W-1:0]     cfg_o
);

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (wr_stb && wr_idx == REG_IDX_W'(g))
                    q <= wr_data;
            end
            assign cfg_o[g*DATA_W +: DATA_W] = q;
        end
    endgenerate

endmodule

// File: rtl/spi_regbank.sv
`timescale 1ns/1ps
module spi_regbank
    import spireg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_i,
    input  logic             mosi_i,
    input  logic             csn_i,
    input  logic             cpol_i,
    input  logic             cpha_i,
    input  logic [BUS_W-1:0] status_i,
    output logic             miso_o,
    output logic [BUS_W-1:0] cfg_o
);

    localparam int SYNC_W = 5;

    logic [SYNC_W-1:0]    sync_q;
    logic                 sclk_s, mosi_s, csn_s, cpol_s, cpha_s;
    logic                 cs_act;
    spi_evt_t             evt;
    logic [ADDR_W-1:0]    peek_addr;
    logic [REG_IDX_W-1:0] peek_idx;
    logic [DATA_W-1:0]    rd_data;
    logic                 wr_stb;
    logic [REG_IDX_W-1:0] wr_idx;
    logic [DATA_W-1:0]    wr_data;

    spireg_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(5'b00100)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cpha_i, cpol_i, csn_i, mosi_i, sclk_i}),
        .q   (sync_q)
    );

    assign {cpha_s, cpol_s, csn_s, mosi_s, sclk_s} = sync_q;
    assign cs_act = ~csn_s;

    spireg_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sclk_s (sclk_s),
        .cpol   (cpol_s),
        .cpha   (cpha_s),
        .cs_act (cs_act),
        .evt    (evt)
    );

    // Read source chosen from the command byte as it completes
    always_comb begin
        peek_idx = reg_index(peek_addr);
        if (is_status_addr(peek_addr))
            rd_data = status_i[int'(peek_idx)*DATA_W +: DATA_W];
        else
            rd_data = cfg_o[int'(peek_idx)*DATA_W +: DATA_W];
    end

    spireg_frame u_frame (
        .clk         (clk),
        .rst         (rst),
        .cs_act      (cs_act),
        .mosi_s      (mosi_s),
        .cpha        (cpha_s),
        .evt         (evt),
        .rd_data_i   (rd_data),
        .peek_addr_o (peek_addr),
        .wr_stb_o    (wr_stb),
        .wr_idx_o    (wr_idx),
        .wr_data_o   (wr_data),
        .miso_o      (miso_o)
    );

    spireg_cfgbank u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .cfg_o   (cfg_o)
    );

endmodule

// File: rtl/spi_regbank_chk.sv
`timescale 1ns/1ps
module spi_regbank_chk
    import spireg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cs_act,
    input logic             evt_sample,
    input logic             evt_shift,
    input logic             wr_stb,
    input logic             miso_o,
    input logic [BUS_W-1:0] cfg_o
);

    // R10: configuration bus only moves right after a write strobe
    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(cfg_o));

    // R1: a commit is a single-cycle strobe
    a_r1_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R7: a commit only follows a selected cycle
    a_r7_commit_selected: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> $past(cs_act));

    // R6: sample and shift events come from opposite SCLK edges
    a_r6_edges_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(evt_sample && evt_shift));

    // R5: MISO is low once deselected
    a_r5_miso_idle: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> !miso_o);

endmodule

bind spi_regbank spi_regbank_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_act     (cs_act),
    .evt_sample (evt.sample),
    .evt_shift  (evt.shift),
    .wr_stb     (wr_stb),
    .miso_o     (miso_o),
    .cfg_o      (cfg_o)
);

// File: tb/spi_regbank_test.sv
`timescale 1ns/1ps
module spi_regbank_test;

    localparam int H = 10;   // SCLK half period in system clocks

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        mosi = 1'b0;
    logic        csn = 1'b1;
    logic        cpol = 1'b0;
    logic        cpha = 1'b0;
    logic [63:0] status;
    logic        miso;
    logic [63:0] cfg;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    spi_regbank uut (
        .clk      (clk),
        .rst      (rst),
        .sclk_i   (sclk),
        .mosi_i   (mosi),
        .csn_i    (csn),
        .cpol_i   (cpol),
        .cpha_i   (cpha),
        .status_i (status),
        .miso_o   (miso),
        .cfg_o    (cfg)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] status_base();
        logic [63:0] v;
        for (int k = 0; k < 8; k++) v[k*8 +: 8] = 8'hA0 + 8'(k);
        return v;
    endfunction

    function automatic logic [15:0] wr_word(input logic [3:0] a, input logic [7:0] d);
        return {1'b1, 3'b000, a, d};
    endfunction

    function automatic logic [15:0] rd_word(input logic [3:0] a);
        return {1'b0, 3'b000, a, 8'h00};
    endfunction

    // One frame; nbits < 16 raises CS early; status flips before bit swap_bit
    task automatic xfer(input logic pol, input logic pha, input logic [15:0] word,
                        input int nbits, input int swap_bit, output logic [15:0] rx);
        rx   = '0;
        cpol = pol;
        cpha = pha;
        sclk = pol;
        wait_clk(2*H);
        csn = 1'b0;
        wait_clk(H);
        for (int i = 15; i >= 16 - nbits; i--) begin
            if (i == swap_bit) status = ~status;
            if (!pha) begin
                mosi = word[i];
                wait_clk(H);
                sclk = ~pol;
                rx[i] = miso;
                wait_clk(H);
                sclk = pol;
            end else begin
                sclk = ~pol;
                mosi = word[i];
                wait_clk(H);
                sclk = pol;
                rx[i] = miso;
                wait_clk(H);
            end
        end
        wait_clk(H);
        csn = 1'b1;
        wait_clk(2*H);
    endtask

    task automatic t_reset();
        chk("R9 cfg after reset", cfg, 64'h0);
        chk("R9 miso after reset", {63'h0, miso}, 64'h0);
    endtask

    task automatic t_modes();
        logic [15:0] rx;
        logic [7:0]  v;
        for (int m = 0; m < 4; m++) begin
            v = {4'(m + 5), ~4'(m)};
            xfer(m[1], m[0], wr_word(4'(m + 1), v), 16, -1, rx);
            chk("R5 miso zero on write", {48'h0, rx}, 64'h0);
            chk("R1 R6 write lands", {56'h0, cfg[(m+1)*8 +: 8]}, {56'h0, v});
            xfer(~m[1], ~m[0], rd_word(4'(m + 1)), 16, -1, rx);
            chk("R3 R5 R6 read config", {48'h0, rx}, {56'h0, v});
        end
    endtask

    task automatic t_dontcare();
        logic [15:0] rx;
        xfer(1'b0, 1'b1, {1'b1, 3'b111, 4'd5, 8'hC3}, 16, -1, rx);
        chk("R2 write with spare bits set", {56'h0, cfg[5*8 +: 8]}, 64'hC3);
        xfer(1'b1, 1'b0, {1'b0, 3'b101, 4'd5, 8'h00}, 16, -1, rx);
        chk("R2 read with spare bits set", {48'h0, rx}, 64'h00C3);
    endtask

    task automatic t_ro_write();
        logic [15:0] rx;
        logic [63:0] snap;
        snap = cfg;
        xfer(1'b0, 1'b0, wr_word(4'hA, 8'hFF), 16, -1, rx);
        chk("R4 write to status addr dropped", cfg, snap);
        xfer(1'b1, 1'b1, wr_word(4'hF, 8'h5A), 16, -1, rx);
        chk("R4 write to addr 15 dropped", cfg, snap);
    endtask

    task automatic t_status_read();
        logic [15:0] rx;
        logic [63:0] snap;
        snap = cfg;
        xfer(1'b1, 1'b1, rd_word(4'h8), 16, -1, rx);
        chk("R3 status slot 0", {48'h0, rx}, 64'h00A0);
        xfer(1'b1, 1'b0, rd_word(4'hF), 16, -1, rx);
        chk("R3 status slot 7", {48'h0, rx}, 64'h00A7);
        xfer(1'b0, 1'b1, rd_word(4'hA), 16, -1, rx);
        chk("R3 status slot 2", {48'h0, rx}, 64'h00A2);
        chk("R10 reads leave config unchanged", cfg, snap);
    endtask

    task automatic t_latch();
        logic [15:0] rx;
        xfer(1'b0, 1'b0, rd_word(4'hC), 16, 4, rx);
        chk("R8 captured status byte", {48'h0, rx}, 64'h00A4);
        xfer(1'b0, 1'b1, rd_word(4'hC), 16, -1, rx);
        chk("R8 next read sees new status", {48'h0, rx}, 64'h005B);
        status = status_base();
    endtask

    task automatic t_abort();
        logic [15:0] rx;
        xfer(1'b0, 1'b0, wr_word(4'd6, 8'h99), 12, -1, rx);
        chk("R7 abort after 12 bits", {56'h0, cfg[6*8 +: 8]}, 64'h0);
        xfer(1'b1, 1'b1, wr_word(4'd6, 8'h99), 15, -1, rx);
        chk("R7 abort after 15 bits", {56'h0, cfg[6*8 +: 8]}, 64'h0);
        xfer(1'b0, 1'b1, wr_word(4'd6, 8'h99), 16, -1, rx);
        chk("R7 full frame after abort", {56'h0, cfg[6*8 +: 8]}, 64'h99);
        xfer(1'b1, 1'b0, wr_word(4'd0, 8'h3E), 16, -1, rx);
        chk("R7 R1 write to reg 0", {56'h0, cfg[7:0]}, 64'h3E);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        status = status_base();
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        t_reset();
        t_modes();
        t_dontcare();
        t_ro_write();
        t_status_read();
        t_latch();
        t_abort();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule